// File: doc/BRIEF.md
# Soft-Start and Over-Current Restart Supervisor

This block governs when a phase-shifted bridge controller may drive its power switches, and how hard it may drive them. It watches a digitised supply level, a flag that says the internal reference has settled, and the output of an over-current comparator. From these it derives a single command that forces every bridge output off, together with a ceiling for the phase command. The ceiling follows a digital soft-start level that climbs one step at a time.

An over-current event trips a fault latch. The latch turns every output off in the same cycle and discharges the soft-start level to zero. The latch then holds the outputs off while the level climbs through its entire range. Only when the level reaches full scale does the latch release, and the level starts again from zero with switching allowed. If the over-current condition is still present at full scale, a new off-time ramp begins. A persistent short therefore produces a slow, regular hiccup of retries instead of continuous stress on the switches. Outside a fault, switching may start at a zero phase command while the ceiling is still at zero.

Top module: `ss_hiccup_sup`

## Requirements
- R1: While `rst_n` is low at a clock edge, all state clears; after that edge `outs_off` is 1 and `phase_clamp` is 0.
- R2: The supply is judged valid from the clock edge at which `vin_code` >= VIN_ON, invalid from the edge at which `vin_code` < VIN_OFF, and unchanged for codes in between (VIN_OFF < VIN_ON gives hysteresis).
- R3: While `ref_ok` is 0, `outs_off` is 1 even with a valid supply, and the soft-start level is held at zero.
- R4: At any edge where the supply is invalid or `ref_ok` is 0, the fault latch and the soft-start level both clear.
- R5: `oc_flag` high forces `outs_off` to 1 in the same cycle, without waiting for a clock edge.
- R6: An edge with the block enabled, `oc_flag` high and the latch clear sets the latch and zeroes the level. This takes priority over any ramp step in that cycle.
- R7: The soft-start level rises by one every PRESCALE clock cycles, counted from the edge at which it was last zeroed. It saturates at the all-ones value 2^SS_W-1.
- R8: `phase_clamp` equals the soft-start level whenever `outs_off` is 0 (including level zero, so switching starts at zero phase), and is 0 whenever `outs_off` is 1.
- R9: While the latch is set and the level is below full scale, `oc_flag` does not restart or pause the ramp.
- R10: The latch stays set until the level reaches full scale. At the next edge with `oc_flag` low the latch clears and the level returns to zero, so switching resumes from zero.
- R11: If `oc_flag` is high at the edge where a latched ramp sits at full scale, the latch stays set and a new ramp from zero begins (hiccup retry).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vin_code | input | VW | Digitised supply level |
| ref_ok | input | 1 | Internal reference has settled |
| oc_flag | input | 1 | Over-current comparator output |
| outs_off | output | 1 | Force all bridge outputs low |
| phase_clamp | output | SS_W | Ceiling for the phase command |

## Verification
Two events can coincide: an over-current trip, and the ramp reaching full scale while the latch is set. The retry decision at full scale must then give a new off-time ramp rather than a release. The bench forces this by holding `oc_flag` high across several full ramps. It also applies single pulses during latched ramps, which must be ignored, and random pulses that land on prescaler ticks and saturation edges. A cycle-accurate model computed from the requirements judges `outs_off` and `phase_clamp` in every cycle.

// File: rtl/ss_hiccup_pkg.sv
// Shared types for the soft-start / over-current restart supervisor.
package ss_hiccup_pkg;
    // Action taken by the soft-start/fault state at the next edge.
    typedef enum logic [1:0] {
        ACT_CLEAR = 2'd0,   // block disabled: everything to zero
        ACT_TRIP  = 2'd1,   // new over-current: set latch, discharge
        ACT_RETRY = 2'd2,   // latched ramp at full scale: release or retry
        ACT_RAMP  = 2'd3    // normal counting
    } ss_act_e;
endpackage

// File: rtl/ss_uvlo_hyst.sv
// Supply-valid detector with hysteresis.
// Assumes VIN_OFF < VIN_ON; codes in between keep the previous decision.
module ss_uvlo_hyst #(
    parameter int VW      = 8,
    parameter int VIN_ON  = 172,
    parameter int VIN_OFF = 148
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vin_code,
    output logic          supply_ok
);
    localparam logic [VW-1:0] ON_CODE  = VW'(VIN_ON);
    localparam logic [VW-1:0] OFF_CODE = VW'(VIN_OFF);

    // Register the valid decision against the two thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n)                   supply_ok <= 1'b0;
        else if (vin_code >= ON_CODE) supply_ok <= 1'b1;
        else if (vin_code < OFF_CODE) supply_ok <= 1'b0;
    end
endmodule

// File: rtl/ss_prescaler.sv
// Divides the clock into single-cycle ramp ticks, one every DIV cycles.
// Assumes restart is high on every edge at which the ramp level is zeroed,
// so the first tick after a discharge comes DIV cycles later.
module ss_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt;

    assign tick = (cnt == LAST);

    // Count cycles, wrapping on each tick and zeroing on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (tick)         cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ss_ramp_latch.sv
// Soft-start level and over-current fault latch.
// A new fault zeroes the level; a latched fault waits for full scale,
// then releases (fault gone) or starts another ramp (fault present).
module ss_ramp_latch
    import ss_hiccup_pkg::*;
#(
    parameter int SS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            oc_flag,
    input  logic            tick,
    output logic            restart,
    output logic            fault,
    output logic [SS_W-1:0] level
);
    localparam logic [SS_W-1:0] FULL = '1;

    ss_act_e act;

    // Choose the action; disable first, then a new trip, then retry.
    always_comb begin
        if (!enable)                    act = ACT_CLEAR;
        else if (oc_flag && !fault)     act = ACT_TRIP;
        else if (fault && level == FULL) act = ACT_RETRY;
        else                            act = ACT_RAMP;
    end

    assign restart = (act != ACT_RAMP);

    // Apply the action to the latch and the level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault <= 1'b0;
            level <= '0;
        end else begin
            unique case (act)
                ACT_CLEAR: begin
                    fault <= 1'b0;
                    level <= '0;
                end
                ACT_TRIP: begin
                    fault <= 1'b1;
                    level <= '0;
                end
                ACT_RETRY: begin
                    fault <= oc_flag;
                    level <= '0;
                end
                default: begin
                    if (tick && level != FULL) level <= level + 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/ss_hiccup_sup.sv
// Top of the supervisor: combines supply/reference gating, the fault latch
// and the soft-start level into an all-off command and a phase ceiling.
// Assumes oc_flag is already synchronous to clk.
module ss_hiccup_sup #(
    parameter int SS_W     = 8,
    parameter int PRESCALE = 16,
    parameter int VW       = 8,
    parameter int VIN_ON   = 172,
    parameter int VIN_OFF  = 148
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VW-1:0]   vin_code,
    input  logic            ref_ok,
    input  logic            oc_flag,
    output logic            outs_off,
    output logic [SS_W-1:0] phase_clamp
);
    logic            sup_ok;
    logic            enable;
    logic            tick;
    logic            restart;
    logic            fault;
    logic [SS_W-1:0] level;

    ss_uvlo_hyst #(.VW(VW), .VIN_ON(VIN_ON), .VIN_OFF(VIN_OFF)) u_uvlo (
        .clk(clk), .rst_n(rst_n), .vin_code(vin_code), .supply_ok(sup_ok)
    );

    assign enable = sup_ok && ref_ok;

    ss_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
    );

    ss_ramp_latch #(.SS_W(SS_W)) u_ramp (
        .clk(clk), .rst_n(rst_n), .enable(enable), .oc_flag(oc_flag),
        .tick(tick), .restart(restart), .fault(fault), .level(level)
    );

    // Outputs off on disable, latched fault, or a live over-current.
    assign outs_off    = !enable || fault || oc_flag;
    assign phase_clamp = outs_off ? '0 : level;
endmodule

// File: rtl/ss_hiccup_chk.sv
// Property checker for ss_hiccup_sup, attached by bind.
module ss_hiccup_chk #(
    parameter int SS_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            oc_flag,
    input logic            sup_ok,
    input logic            ref_ok,
    input logic            fault,
    input logic [SS_W-1:0] level,
    input logic            outs_off,
    input logic [SS_W-1:0] phase_clamp
);
    localparam logic [SS_W-1:0] FULL = '1;

    AST_OC_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oc_flag |-> outs_off);                                          // R5
    AST_OFF_CLAMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        outs_off |-> (phase_clamp == '0));                              // R8
    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (level == $past(level) || level == '0
                  || level == $past(level) + 1'b1));                    // R7
    AST_TRIP_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_ok && ref_ok && oc_flag && !fault) |=> (fault && level == '0)); // R6
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_ok && ref_ok && fault && level != FULL) |=> fault);        // R10
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !(sup_ok && ref_ok) |=> (!fault && level == '0));               // R4
endmodule

bind ss_hiccup_sup ss_hiccup_chk #(.SS_W(SS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .sup_ok(sup_ok),
    .ref_ok(ref_ok), .fault(fault), .level(level), .outs_off(outs_off),
    .phase_clamp(phase_clamp)
);

// File: tb/test_ss_hiccup_sup.sv
`timescale 1ns/1ps
module test_ss_hiccup_sup;
    localparam int SS_W = 4;
    localparam int DIV  = 3;
    localparam int VW   = 6;
    localparam int VON  = 40;
    localparam int VOFF = 30;
    localparam logic [SS_W-1:0] FULL = '1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [VW-1:0]   vin_code = '0;
    logic            ref_ok = 1'b0;
    logic            oc_flag = 1'b0;
    logic            outs_off;
    logic [SS_W-1:0] phase_clamp;

    int checks = 0;
    int errors = 0;

    // Reference model state, derived from the requirements.
    logic            m_sup = 1'b0;
    logic            m_flt = 1'b0;
    logic [SS_W-1:0] m_ss  = '0;
    int              m_pc  = 0;

    always #2.5 clk = ~clk;

    ss_hiccup_sup #(.SS_W(SS_W), .PRESCALE(DIV), .VW(VW),
                    .VIN_ON(VON), .VIN_OFF(VOFF)) i_ss_hiccup_sup (
        .clk(clk), .rst_n(rst_n), .vin_code(vin_code), .ref_ok(ref_ok),
        .oc_flag(oc_flag), .outs_off(outs_off), .phase_clamp(phase_clamp)
    );

    function automatic logic exp_off();
        return !(m_sup && ref_ok) || m_flt || oc_flag;
    endfunction

    function automatic logic [SS_W-1:0] exp_phase();
        return exp_off() ? '0 : m_ss;
    endfunction

    task automatic model_edge();
        logic en;
        en = m_sup && ref_ok;
        if (!rst_n) begin
            m_sup = 1'b0; m_flt = 1'b0; m_ss = '0; m_pc = 0;
        end else begin
            if (!en) begin
                m_flt = 1'b0; m_ss = '0; m_pc = 0;
            end else if (oc_flag && !m_flt) begin
                m_flt = 1'b1; m_ss = '0; m_pc = 0;
            end else if (m_flt && m_ss == FULL) begin
                m_flt = oc_flag; m_ss = '0; m_pc = 0;
            end else if (m_pc == DIV - 1) begin
                m_pc = 0;
                if (m_ss != FULL) m_ss = m_ss + 1'b1;
            end else begin
                m_pc = m_pc + 1;
            end
            if (vin_code >= VW'(VON))      m_sup = 1'b1;
            else if (vin_code < VW'(VOFF)) m_sup = 1'b0;
        end
    endtask

    task automatic chk1(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: check outputs mid-cycle, advance the model at the edge.
    task automatic cyc(input string r_off, input string r_ph);
        #1;
        chk1(int'(outs_off), int'(exp_off()), r_off);
        chk1(int'(phase_clamp), int'(exp_phase()), r_ph);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic run(input int n, input string r_off, input string r_ph);
        for (int i = 0; i < n; i++) cyc(r_off, r_ph);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd7421));
        @(negedge clk);
        // R1: reset state
        run(3, "R1", "R1");
        rst_n = 1'b1;
        // R2: code between thresholds from reset keeps supply invalid
        vin_code = 6'd35; ref_ok = 1'b1;
        run(4, "R2", "R2");
        // R2 then R3: supply valid but reference not ready
        vin_code = 6'd45; ref_ok = 1'b0;
        run(6, "R3", "R3");
        // R8: switching allowed at level zero; R7: ramp to saturation
        ref_ok = 1'b1;
        run(2, "R8", "R8");
        run(55, "R7", "R7");
        chk1(int'(phase_clamp), int'(FULL), "R7");
        // R2: hysteresis band keeps valid, below off threshold drops
        vin_code = 6'd33;
        run(5, "R2", "R2");
        vin_code = 6'd25;
        run(3, "R4", "R4");
        vin_code = 6'd50;
        run(20, "R7", "R8");
        // R5 and R6: single-cycle trip mid-ramp
        oc_flag = 1'b1;
        cyc("R5", "R6");
        oc_flag = 1'b0;
        run(10, "R6", "R6");
        // R9: pulses during latched ramp are ignored
        for (int k = 0; k < 3; k++) begin
            oc_flag = 1'b1; cyc("R9", "R9");
            oc_flag = 1'b0; run(6, "R9", "R9");
        end
        // R10: release only after full scale
        run(40, "R10", "R10");
        chk1(int'(outs_off), 0, "R10");
        // R11: continuous fault produces repeated off-time ramps
        oc_flag = 1'b1;
        run(160, "R11", "R11");
        chk1(int'(outs_off), 1, "R11");
        oc_flag = 1'b0;
        run(60, "R10", "R10");
        // R4: reference drop clears latch mid-fault
        oc_flag = 1'b1; cyc("R5", "R6");
        oc_flag = 1'b0; run(5, "R9", "R9");
        ref_ok = 1'b0; run(3, "R4", "R4");
        ref_ok = 1'b1; run(4, "R4", "R8");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            oc_flag  = ($urandom_range(0, 39) == 0);
            ref_ok   = ($urandom_range(0, 199) != 0);
            vin_code = ($urandom_range(0, 99) < 3) ? VW'($urandom_range(20, 45))
                                                   : VW'($urandom_range(41, 63));
            if ($urandom_range(0, 999) == 0) rst_n = 1'b0; else rst_n = 1'b1;
            cyc("R5", "R8");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule